// File: doc/BRIEF.md
# PLL Reference Select and Divider Front-End

This block holds the digital control path that sits around an analog phase-locked loop. It picks the loop reference from either an external clock pin or an external horizontal sync pin. It can invert either pin. When the clock pin is the source, the block prescales it by a programmable ratio. It runs the feedback and output divider counters on ticks from the oscillator. It also reports when the loop may be treated as settled after a divider change. Everything runs on one system clock. Both reference pins are sampled as levels. The oscillator is seen as a one-cycle strobe `vco_tick`. Every divider output is a one-cycle enable pulse, not a generated clock.

Software loads four fields through a small write port. Address 0 holds the control field, address 1 the prescaler, address 2 the feedback divider and address 3 the output divider. The divider fields are stored offset-encoded. Each counter picks up a new field value only at its next terminal count, so a period already running is never cut short. The settle controller is a three-state machine:
- `ST_IDLE`: the state after reset. Stable is low and no divider has been written yet.
- `ST_SETTLE`: the window is being timed.
- `ST_STABLE`: the window ended with no further divider write.

Its transitions are:
- IDLE to SETTLE on a divider write.
- SETTLE to SETTLE on another divider write, which restarts the window.
- SETTLE to STABLE when the window completes.
- STABLE to SETTLE on a divider write.

Top module: `pllfe_top`

## Requirements
- R1: A synchronous active-high reset clears every field to zero and sets the settle machine to ST_IDLE. In the cycle after reset, `ref_level`, `ref_pulse`, `fb_pulse`, `fout2x_tick`, `fout_tick` and `stable` are all 0.
- R2: Source select is control bits [2:0]. Code 000 forces the reference low. Codes 001, 011 and 100 select the external clock. Code 010 selects the horizontal sync. Codes 101 to 111 also force the reference low. `ref_level` shows the selected level sampled at the previous clock edge.
- R3: Control bit 3 inverts the external clock pin. Control bit 4 inverts the sync pin. When a bit is 0 its pin passes unchanged.
- R4: When a clock code is selected, a rising reference level counts toward the prescaler. With value v in wr_data[5:0] at address 1, `ref_pulse` fires on the first counted rise after reset and then on every (v+1)-th rise. The pulse is high for the single cycle after the edge that sampled the rise.
- R5: When the sync code is selected, every rising reference level gives a `ref_pulse` in the cycle after the sampling edge. The prescaler is bypassed and left untouched.
- R6: The feedback field at address 2 is wr_data[11:0] and holds N-2. Once running, `fb_pulse` fires on every N-th `vco_tick`. The first tick after reset fires it. The pulse appears in the cycle after the edge that sampled the tick.
- R7: The output field at address 3 is wr_data[3:0] and holds M-1. `fout2x_tick` fires on every M-th `vco_tick`, with the same first-tick and latency rules as R6.
- R8: `fout_tick` fires on every second `fout2x_tick`, starting with the second one after reset. It lags that `fout2x_tick` by one cycle, so it runs at half the rate.
- R9: A new divider or prescaler value takes effect only when its counter next reaches terminal count. The period already in progress completes at the old length.
- R10: `stable` rises exactly SETTLE_CYC cycles after the edge that accepted a write to address 2 or 3. Any such write restarts the window and drops `stable` in the next cycle. SETTLE_CYC is (SYS_CLK_HZ/1000)*SETTLE_US/1000, and SETTLE_US defaults to 3000.
- R11: Writes to address 0 or 1 neither start nor restart the settle window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 2 | Field address (0 control, 1 prescaler, 2 feedback, 3 output) |
| wr_data | input | FB_W | Write data, right-aligned, as wide as the widest field |
| ext_clk_in | input | 1 | External clock reference pin, sampled as a level |
| hsync_in | input | 1 | External horizontal sync pin, sampled as a level |
| vco_tick | input | 1 | One-cycle strobe per oscillator period |
| ref_level | output | 1 | Selected, polarity-corrected reference level |
| ref_pulse | output | 1 | Prescaled reference enable pulse |
| fb_pulse | output | 1 | Feedback divider terminal pulse (divide by N) |
| fout2x_tick | output | 1 | Output divider terminal pulse (divide by M) |
| fout_tick | output | 1 | Half-rate output pulse |
| stable | output | 1 | Settle window complete since the last divider write |

## Verification
The bench builds the block with SYS_CLK_HZ set to 20000, which shrinks the settle window to 60 cycles. At that length it can reach window completion, restart by a second divider write, and the case where writes to addresses 0 and 1 land during settling. The field widths stay at their defaults. This lets the bench run the extremes N=4097, M=16 and a prescale ratio of 64 within the cycle budget. A per-cycle scoreboard compares every pulse and level against a behavioural model.

// File: rtl/pllfe_pkg.sv
package pllfe_pkg;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_PRE  = 2'd1;
    localparam logic [1:0] ADDR_FB   = 2'd2;
    localparam logic [1:0] ADDR_OUT  = 2'd3;

    localparam logic [2:0] SRC_OFF   = 3'd0;
    localparam logic [2:0] SRC_CLK   = 3'd1;
    localparam logic [2:0] SRC_SYNC  = 3'd2;
    localparam logic [2:0] SRC_CLK_B = 3'd3;
    localparam logic [2:0] SRC_CLK_C = 3'd4;

    typedef struct packed {
        logic       hs_inv;
        logic       clk_inv;
        logic [2:0] src;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_STABLE = 2'd2
    } settle_state_t;

endpackage

// File: rtl/pllfe_regs.sv
module pllfe_regs
    import pllfe_pkg::*;
#(
    parameter int PRE_W = 6,
    parameter int FB_W  = 12,
    parameter int OUT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [FB_W-1:0]  wr_data,
    output ctrl_t            ctrl,
    output logic [PRE_W-1:0] pre_val,
    output logic [FB_W-1:0]  fb_val,
    output logic [OUT_W-1:0] out_val,
    output logic             div_wr
);

    localparam int CTRL_W = $bits(ctrl_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            pre_val <= '0;
            fb_val  <= '0;
            out_val <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_CTRL: ctrl    <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADDR_PRE:  pre_val <= wr_data[PRE_W-1:0];
                ADDR_FB:   fb_val  <= wr_data;
                default:   out_val <= wr_data[OUT_W-1:0];
            endcase
        end
    end

    always_comb begin
        div_wr = wr_en && ((wr_addr == ADDR_FB) || (wr_addr == ADDR_OUT));
    end

endmodule

// File: rtl/pllfe_refpath.sv
module pllfe_refpath
    import pllfe_pkg::*;
#(
    parameter int PRE_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [PRE_W-1:0] pre_val,
    input  logic             ext_clk_in,
    input  logic             hsync_in,
    output logic             ref_level,
    output logic             ref_pulse
);

    logic             clk_lvl;
    logic             hs_lvl;
    logic             sel_lvl;
    logic             use_pre;
    logic             rise;
    logic             ref_q;
    logic [PRE_W-1:0] pcnt;

    always_comb begin
        clk_lvl = ext_clk_in ^ ctrl.clk_inv;
        hs_lvl  = hsync_in ^ ctrl.hs_inv;
        sel_lvl = 1'b0;
        use_pre = 1'b0;
        case (ctrl.src)
            SRC_CLK, SRC_CLK_B, SRC_CLK_C: begin
                sel_lvl = clk_lvl;
                use_pre = 1'b1;
            end
            SRC_SYNC: sel_lvl = hs_lvl;
            default:  sel_lvl = 1'b0;
        endcase
        rise = sel_lvl & ~ref_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q     <= 1'b0;
            pcnt      <= '0;
            ref_pulse <= 1'b0;
        end else begin
            ref_q     <= sel_lvl;
            ref_pulse <= 1'b0;
            if (rise) begin
                if (!use_pre) begin
                    ref_pulse <= 1'b1;
                end else if (pcnt == '0) begin
                    ref_pulse <= 1'b1;
                    pcnt      <= pre_val;
                end else begin
                    pcnt <= pcnt - 1'b1;
                end
            end
        end
    end

    assign ref_level = ref_q;

    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (ref_q && !$past(ref_q))); // R4

    AST_OFF_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(ctrl.src) == SRC_OFF) |-> !ref_q); // R2

endmodule

// File: rtl/pllfe_divider.sv
module pllfe_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         tc
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (tick) begin
                if (cnt == '0) begin
                    tc  <= 1'b1;
                    cnt <= reload;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    AST_TC_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
        tc |-> $past(tick)); // R6

endmodule

// File: rtl/pllfe_settle.sv
module pllfe_settle
    import pllfe_pkg::*;
#(
    parameter int SETTLE_CYC = 750000
) (
    input  logic clk,
    input  logic rst,
    input  logic div_wr,
    output logic stable
);

    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    settle_state_t state;
    settle_state_t state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (div_wr) state_nx = ST_SETTLE;
            ST_SETTLE: begin
                if (div_wr)           state_nx = ST_SETTLE;
                else if (cnt == LAST) state_nx = ST_STABLE;
            end
            ST_STABLE: if (div_wr) state_nx = ST_SETTLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || div_wr)                         cnt <= '0;
        else if (state == ST_SETTLE && cnt != LAST) cnt <= cnt + 1'b1;
    end

    always_comb begin
        stable = (state == ST_STABLE);
    end

    AST_WRITE_DROPS_STABLE: assert property (@(posedge clk) disable iff (rst)
        div_wr |=> !stable); // R10

    AST_STABLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stable && !div_wr) |=> stable); // R10

endmodule

// File: rtl/pllfe_top.sv
module pllfe_top
    import pllfe_pkg::*;
#(
    parameter int PRE_W      = 6,
    parameter int FB_W       = 12,
    parameter int OUT_W      = 4,
    parameter int SYS_CLK_HZ = 250000000,
    parameter int SETTLE_US  = 3000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [FB_W-1:0] wr_data,
    input  logic            ext_clk_in,
    input  logic            hsync_in,
    input  logic            vco_tick,
    output logic            ref_level,
    output logic            ref_pulse,
    output logic            fb_pulse,
    output logic            fout2x_tick,
    output logic            fout_tick,
    output logic            stable
);

    localparam int SETTLE_CYC = (SYS_CLK_HZ / 1000) * SETTLE_US / 1000;
    localparam int FBR_W      = FB_W + 1;

    ctrl_t            ctrl;
    logic [PRE_W-1:0] pre_val;
    logic [FB_W-1:0]  fb_val;
    logic [OUT_W-1:0] out_val;
    logic             div_wr;
    logic [FBR_W-1:0] fb_reload;
    logic             half_q;

    pllfe_regs #(.PRE_W(PRE_W), .FB_W(FB_W), .OUT_W(OUT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .pre_val(pre_val),
        .fb_val(fb_val), .out_val(out_val), .div_wr(div_wr)
    );

    pllfe_refpath #(.PRE_W(PRE_W)) u_ref (
        .clk(clk), .rst(rst), .ctrl(ctrl), .pre_val(pre_val),
        .ext_clk_in(ext_clk_in), .hsync_in(hsync_in),
        .ref_level(ref_level), .ref_pulse(ref_pulse)
    );

    // feedback period N = field + 2, so the counter reloads field + 1
    assign fb_reload = {1'b0, fb_val} + FBR_W'(1);

    pllfe_divider #(.W(FBR_W)) u_fb (
        .clk(clk), .rst(rst), .tick(vco_tick), .reload(fb_reload),
        .tc(fb_pulse)
    );

    pllfe_divider #(.W(OUT_W)) u_out (
        .clk(clk), .rst(rst), .tick(vco_tick), .reload(out_val),
        .tc(fout2x_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            half_q    <= 1'b0;
            fout_tick <= 1'b0;
        end else begin
            fout_tick <= 1'b0;
            if (fout2x_tick) begin
                fout_tick <= half_q;
                half_q    <= ~half_q;
            end
        end
    end

    pllfe_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .div_wr(div_wr), .stable(stable)
    );

    AST_FOUT_AFTER_2X: assert property (@(posedge clk) disable iff (rst)
        fout_tick |-> $past(fout2x_tick)); // R8

endmodule

// File: tb/tb_pllfe_top.sv
module tb_pllfe_top;

    localparam int FB_W = 12;
    localparam int SC   = 60; // (20000/1000)*3000/1000

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [FB_W-1:0] wr_data = '0;
    logic ext_clk_in = 1'b0;
    logic hsync_in = 1'b0;
    logic vco_tick = 1'b0;
    logic ref_level, ref_pulse, fb_pulse, fout2x_tick, fout_tick, stable;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int q_ref[$];
    int q_fb[$];
    int q_2x[$];
    int q_f[$];

    // model state
    bit [2:0] m_src = 0;
    bit m_ci = 0, m_hi = 0;
    int m_pre = 0, m_fb = 0, m_out = 0;
    int m_pc = 0, m_fc = 0, m_oc = 0;
    bit m_h = 0, m_refq = 0;
    bit m_settling = 0, m_stable = 0;
    int m_sc = 0;
    bit exp_lvl = 0, exp_stable = 0;

    pllfe_top #(.SYS_CLK_HZ(20000)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_clk_in(ext_clk_in), .hsync_in(hsync_in),
        .vco_tick(vco_tick), .ref_level(ref_level), .ref_pulse(ref_pulse),
        .fb_pulse(fb_pulse), .fout2x_tick(fout2x_tick),
        .fout_tick(fout_tick), .stable(stable)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: got %0d expected %0d", req, cyc, act, exp_v);
        end
    endtask

    task automatic chk_pulse(input logic seen, ref int q[$], input string req);
        bit want;
        want = (q.size() > 0) && (q[0] == cyc);
        if (want) void'(q.pop_front());
        check(seen == want, req, int'(seen), int'(want));
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            check(ref_level == exp_lvl, "R2/R3 ref_level", int'(ref_level), int'(exp_lvl));
            check(stable == exp_stable, "R10/R11 stable", int'(stable), int'(exp_stable));
            chk_pulse(ref_pulse, q_ref, "R4/R5 ref_pulse");
            chk_pulse(fb_pulse, q_fb, "R6/R9 fb_pulse");
            chk_pulse(fout2x_tick, q_2x, "R7/R9 fout2x_tick");
            chk_pulse(fout_tick, q_f, "R8 fout_tick");
        end
    end

    function automatic bit is_clk_src(input bit [2:0] s);
        return (s == 3'd1) || (s == 3'd3) || (s == 3'd4);
    endfunction

    // driver: one cycle of stimulus, model predicts results of the next edge
    task automatic cycle(input bit t, input bit we, input bit [1:0] a,
                         input int d, input bit ck, input bit hs);
        int e;
        bit lvl;
        @(negedge clk);
        #1;
        vco_tick = t; wr_en = we; wr_addr = a; wr_data = FB_W'(d);
        ext_clk_in = ck; hsync_in = hs;
        e = cyc + 1;
        lvl = is_clk_src(m_src) ? (ck ^ m_ci) : (m_src == 3'd2) ? (hs ^ m_hi) : 1'b0;
        if (lvl && !m_refq) begin
            if (m_src == 3'd2) q_ref.push_back(e);
            else if (is_clk_src(m_src)) begin
                if (m_pc == 0) begin q_ref.push_back(e); m_pc = m_pre; end
                else m_pc--;
            end
        end
        m_refq = lvl;
        exp_lvl = lvl;
        if (t) begin
            if (m_fc == 0) begin q_fb.push_back(e); m_fc = m_fb + 1; end
            else m_fc--;
            if (m_oc == 0) begin
                q_2x.push_back(e); m_oc = m_out;
                if (m_h) q_f.push_back(e + 1);
                m_h = !m_h;
            end else m_oc--;
        end
        if (we && (a == 2'd2 || a == 2'd3)) begin
            m_settling = 1; m_sc = 0; m_stable = 0;
        end else if (m_settling) begin
            if (m_sc == SC - 1) begin m_stable = 1; m_settling = 0; end
            else m_sc++;
        end
        exp_stable = m_stable;
        if (we) begin
            case (a)
                2'd0: begin m_src = d[2:0]; m_ci = d[3]; m_hi = d[4]; end
                2'd1: m_pre = d & 63;
                2'd2: m_fb = d & 4095;
                default: m_out = d & 15;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 0, 0, 0, ext_clk_in, hsync_in);
    endtask
    task automatic wr(input bit [1:0] a, input int d);
        cycle(0, 1, a, d, ext_clk_in, hsync_in);
    endtask
    task automatic vco(input int n);
        for (int i = 0; i < n; i++) cycle(1, 0, 0, 0, ext_clk_in, hsync_in);
    endtask
    // rising edge on the post-inversion clock level; sync pin toggles as noise
    task automatic clk_rises(input int n);
        for (int i = 0; i < n; i++) begin
            cycle(0, 0, 0, 0, m_ci, 1'b0);
            cycle(0, 0, 0, 0, !m_ci, 1'b1);
        end
    endtask
    // rising edge on the post-inversion sync level; clock pin toggles as noise
    task automatic hs_rises(input int n);
        for (int i = 0; i < n; i++) begin
            cycle(0, 0, 0, 0, 1'b1, m_hi);
            cycle(0, 0, 0, 0, 1'b0, !m_hi);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        #1 rst = 1'b0;
        // R1: reset state at the ports
        check({ref_level, ref_pulse, fb_pulse, fout2x_tick, fout_tick, stable} == 6'b0,
              "R1 reset outputs", int'({ref_level, ref_pulse, fb_pulse, fout2x_tick, fout_tick, stable}), 0);
        // R1/R2: fields zero -> source off, pins ignored
        clk_rises(3); hs_rises(3);
        // R6/R7/R8: N=2, M=1 from reset values
        vco(6); idle(3);
        // R4: prescale ratio 1 on the external clock
        wr(0, 1); clk_rises(4);
        // R4/R9: ratio 3, takes effect after the next terminal count
        wr(1, 2); clk_rises(10);
        // R3: inverted clock pin
        wr(0, 1 | 8); clk_rises(7);
        // R5/R3: sync source, plain then inverted
        wr(0, 2); hs_rises(4); clk_rises(2);
        wr(0, 2 | 16); hs_rises(4);
        // R2: aliased clock codes and fixed-low codes
        wr(0, 3); clk_rises(4); hs_rises(2);
        wr(0, 4); clk_rises(4);
        wr(0, 5); clk_rises(3); hs_rises(3);
        wr(0, 7); clk_rises(3);
        wr(0, 0); clk_rises(2);
        // R6/R7/R9/R10: divider changes mid-period
        wr(2, 3); vco(3); wr(3, 3); vco(13);
        wr(2, 856); vco(5); wr(3, 15); vco(1800);
        idle(SC + 5);
        // R10: restart, R11: control/prescaler writes do not restart
        wr(2, 10); idle(30); wr(3, 2); idle(20);
        wr(1, 5); idle(10); wr(0, 1); idle(SC);
        // R6 boundary: N = 4097
        wr(2, 4095); vco(8300);
        // R4 boundary: ratio 64
        wr(0, 1); wr(1, 63); clk_rises(140);
        idle(10);
        check(q_ref.size() + q_fb.size() + q_2x.size() + q_f.size() == 0,
              "R4/R6/R7/R8 pending pulses", q_ref.size() + q_fb.size() + q_2x.size() + q_f.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule